// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides, cycle by cycle, whether a processor core must enter an exception handler or return from one, and it produces the program counter and status word the core loads next. Seven request lines arrive as levels: reset, undefined instruction, supervisor call, prefetch abort, data abort, normal interrupt and fast interrupt. Alongside them come the core's current program counter and status word. The status word holds the mode in bits [4:0], the instruction-set state bit in bit 5, the fast-interrupt mask in bit 6, the interrupt mask in bit 7 and the condition flags in the upper bits.

On entry, the block writes the current status word and the return address into a bank that belongs to the target mode. It then builds the new status word and sends the core to a fixed vector slot at the bottom of the address map. A separate return command reads back the bank of the mode the core is in. It hands the saved program counter and status word back to the core, which lets nested exceptions in different modes unwind in order.

All outputs are registered. A decision taken from the inputs seen at one rising edge shows on the outputs just after that edge and lasts one cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: An entry sets `out_pc` to `VEC_BASE + 4*slot` and reports the slot on `out_slot`. The slots are: reset 0, undefined 1, supervisor call 2, prefetch abort 3, data abort 4, unused 5, interrupt 6, fast interrupt 7. Slot 5 is never reported.
- R2: When several enabled requests are active together, exactly one is taken, in this order from highest to lowest: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, supervisor call.
- R3: An interrupt request is ignored while `cur_psr[7]` is 1. A fast-interrupt request is ignored while `cur_psr[6]` is 1. With no other request pending, no output pulse follows.
- R4: The new mode field `out_psr[4:0]` depends on the request taken. Reset and supervisor call give 10011. Undefined gives 11011. Both aborts give 10111. Interrupt gives 10010. Fast interrupt gives 10001.
- R5: Every entry sets `out_psr[7]`. A fast-interrupt entry or a reset also sets `out_psr[6]`. Every other entry copies bit 6 from `cur_psr`.
- R6: On every entry, `out_psr[5]` is forced to the parameter `VEC_T`. On a non-reset entry, every bit above bit 7 is copied from `cur_psr`.
- R7: A non-reset entry pulses `bank_we`. In the same cycle it shows the target mode on `bank_mode`, the old `cur_psr` on `bank_psr` and `cur_pc` on `bank_lr`, and it stores these into that mode's bank.
- R8: A reset request produces `out_pc = VEC_BASE` and a status word that is zero except for mode 10011, bits 6 and 7 set, and bit 5 equal to `VEC_T`. It writes no bank.
- R9: A return command in a mode that has a bank (10001, 10010, 10011, 10111, 11011) pulses `out_valid` with `out_ret` = 1. `out_pc` and `out_psr` take the values last stored for that mode, and no bank is written.
- R10: A return command in user mode (10000) or any other mode without a bank produces no output pulse.
- R11: Outputs appear one cycle after the inputs are sampled, and `out_valid` is high for that one cycle only. A synchronous `rst` clears `out_valid` on the next edge, even if requests are pending.
- R12: When an enabled request and a return command arrive in the same cycle, the entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_svc | input | 1 | Supervisor call request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| ret_cmd | input | 1 | Exception return command |
| cur_pc | input | AW | Return address to save on entry |
| cur_psr | input | PW | Current status word |
| out_valid | output | 1 | One-cycle pulse: new PC and status are valid |
| out_ret | output | 1 | The pulse is a return (1) or an entry (0) |
| out_slot | output | 3 | Vector slot of the entry taken |
| out_pc | output | AW | Program counter to load |
| out_psr | output | PW | Status word to load |
| bank_we | output | 1 | A bank write took place |
| bank_mode | output | 5 | Mode whose bank was written |
| bank_psr | output | PW | Status word saved into the bank |
| bank_lr | output | AW | Return address saved into the bank |

## Verification
The assertions assume that `cur_psr` and `cur_pc` describe the core as it stands at each request. In particular, a return command is only issued in a mode whose bank was filled by an earlier entry, because the bank storage has no reset and is undefined until written. The bench respects this: before each return it feeds back the status word that the previous entry produced, and it issues returns in the reverse order of the entries. The one deliberate exception is a return in user mode, which has no bank to read. Requests are held for one cycle only and dropped before the next edge, so every output pulse can be traced to a single set of inputs.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NSLOT   = 8;
  localparam int SLOT_W  = 3;
  localparam int NBANK   = 5;
  localparam int BANK_IW = 3;

  localparam logic [SLOT_W-1:0] SLOT_RST  = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_UND  = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_SVC  = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_PABT = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_DABT = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_RSVD = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_IRQ  = 3'd6;
  localparam logic [SLOT_W-1:0] SLOT_FIQ  = 3'd7;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int PSR_T = 5;
  localparam int PSR_F = 6;
  localparam int PSR_I = 7;

  // highest priority first
  localparam int NPRIO = 7;
  localparam logic [SLOT_W-1:0] PRIO_ORDER [NPRIO] = '{
    SLOT_RST, SLOT_DABT, SLOT_FIQ, SLOT_IRQ, SLOT_PABT, SLOT_UND, SLOT_SVC
  };

  function automatic logic [4:0] slot_mode(input logic [SLOT_W-1:0] s);
    case (s)
      SLOT_UND:             return MODE_UND;
      SLOT_PABT, SLOT_DABT: return MODE_ABT;
      SLOT_IRQ:             return MODE_IRQ;
      SLOT_FIQ:             return MODE_FIQ;
      default:              return MODE_SVC;
    endcase
  endfunction

  // {has_bank, index}
  function automatic logic [BANK_IW:0] mode_bank(input logic [4:0] m);
    case (m)
      MODE_FIQ: return {1'b1, 3'd0};
      MODE_IRQ: return {1'b1, 3'd1};
      MODE_SVC: return {1'b1, 3'd2};
      MODE_ABT: return {1'b1, 3'd3};
      MODE_UND: return {1'b1, 3'd4};
      default:  return {1'b0, 3'd0};
    endcase
  endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_pkg::*;
(
  input  logic [NSLOT-1:0]  req,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);

  always_comb begin
    hit  = 1'b0;
    slot = SLOT_RST;
    // walk from lowest priority up, so the highest active one wins
    for (int k = NPRIO - 1; k >= 0; k--) begin
      if (req[PRIO_ORDER[k]]) begin
        hit  = 1'b1;
        slot = PRIO_ORDER[k];
      end
    end
  end

endmodule

// File: rtl/exc_psr_form.sv
module exc_psr_form
  import exc_pkg::*;
#(
  parameter int   PW    = 32,
  parameter logic VEC_T = 1'b0
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [PW-1:0]     cur,
  output logic [PW-1:0]     nxt
);

  always_comb begin
    nxt = cur;
    if (slot == SLOT_RST) begin
      nxt        = '0;
      nxt[PSR_F] = 1'b1;
    end
    if (slot == SLOT_FIQ) nxt[PSR_F] = 1'b1;
    nxt[4:0]   = slot_mode(slot);
    nxt[PSR_T] = VEC_T;
    nxt[PSR_I] = 1'b1;
  end

endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file #(
  parameter int DW    = 64,
  parameter int DEPTH = 5,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            PW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0,
  parameter logic          VEC_T    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rst,
  input  logic              req_und,
  input  logic              req_svc,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              req_irq,
  input  logic              req_fiq,
  input  logic              ret_cmd,
  input  logic [AW-1:0]     cur_pc,
  input  logic [PW-1:0]     cur_psr,
  output logic              out_valid,
  output logic              out_ret,
  output logic [SLOT_W-1:0] out_slot,
  output logic [AW-1:0]     out_pc,
  output logic [PW-1:0]     out_psr,
  output logic              bank_we,
  output logic [4:0]        bank_mode,
  output logic [PW-1:0]     bank_psr,
  output logic [AW-1:0]     bank_lr
);

  localparam int BDW = PW + AW;

  logic [NSLOT-1:0]  req_vec;
  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic [PW-1:0]     nxt_psr;
  logic [4:0]        tgt_mode;
  logic [BANK_IW:0]  wr_sel, rd_sel;
  logic              wr_en, do_ret;
  logic [BDW-1:0]    rd_word;
  logic [AW-1:0]     vec_pc;

  always_comb begin
    req_vec            = '0;
    req_vec[SLOT_RST]  = req_rst;
    req_vec[SLOT_UND]  = req_und;
    req_vec[SLOT_SVC]  = req_svc;
    req_vec[SLOT_PABT] = req_pabt;
    req_vec[SLOT_DABT] = req_dabt;
    req_vec[SLOT_RSVD] = 1'b0;
    req_vec[SLOT_IRQ]  = req_irq & ~cur_psr[PSR_I];
    req_vec[SLOT_FIQ]  = req_fiq & ~cur_psr[PSR_F];
  end

  exc_prio_arb u_arb (
    .req  (req_vec),
    .hit  (hit),
    .slot (slot)
  );

  exc_psr_form #(.PW(PW), .VEC_T(VEC_T)) u_form (
    .slot (slot),
    .cur  (cur_psr),
    .nxt  (nxt_psr)
  );

  assign tgt_mode = slot_mode(slot);
  assign wr_sel   = mode_bank(tgt_mode);
  assign rd_sel   = mode_bank(cur_psr[4:0]);
  assign wr_en    = hit && (slot != SLOT_RST);
  assign do_ret   = !hit && ret_cmd && rd_sel[BANK_IW];
  assign vec_pc   = VEC_BASE + AW'({slot, 2'b00});

  exc_bank_file #(.DW(BDW), .DEPTH(NBANK), .IW(BANK_IW)) u_bank (
    .clk   (clk),
    .we    (wr_en),
    .widx  (wr_sel[BANK_IW-1:0]),
    .wdata ({cur_psr, cur_pc}),
    .ridx  (rd_sel[BANK_IW-1:0]),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ret   <= 1'b0;
      out_slot  <= '0;
      out_pc    <= '0;
      out_psr   <= '0;
      bank_we   <= 1'b0;
      bank_mode <= '0;
      bank_psr  <= '0;
      bank_lr   <= '0;
    end else begin
      out_valid <= hit || do_ret;
      out_ret   <= do_ret;
      bank_we   <= wr_en;
      if (hit) begin
        out_slot  <= slot;
        out_pc    <= vec_pc;
        out_psr   <= nxt_psr;
        bank_mode <= tgt_mode;
        bank_psr  <= cur_psr;
        bank_lr   <= cur_pc;
      end else if (do_ret) begin
        out_slot <= '0;
        out_pc   <= rd_word[AW-1:0];
        out_psr  <= rd_word[BDW-1:AW];
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            PW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0,
  parameter logic          VEC_T    = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_rst,
  input logic              req_und,
  input logic              req_svc,
  input logic              req_pabt,
  input logic              req_dabt,
  input logic              req_irq,
  input logic              req_fiq,
  input logic              ret_cmd,
  input logic [PW-1:0]     cur_psr,
  input logic              out_valid,
  input logic              out_ret,
  input logic [SLOT_W-1:0] out_slot,
  input logic [AW-1:0]     out_pc,
  input logic [PW-1:0]     out_psr,
  input logic              bank_we,
  input logic [4:0]        bank_mode
);

  logic others_idle;
  assign others_idle = !req_rst && !req_und && !req_svc && !req_pabt && !req_dabt;

  a_r1_vec_addr: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ret) |-> (out_pc == VEC_BASE + AW'({out_slot, 2'b00})));

  a_r1_no_rsvd: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slot != SLOT_RSVD));

  a_r3_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (req_irq && cur_psr[PSR_I] && !req_fiq && others_idle && !ret_cmd) |=> !out_valid);

  a_r4_fiq_mode: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ret && out_slot == SLOT_FIQ) |-> (out_psr[4:0] == MODE_FIQ));

  a_r5_irq_mask: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ret) |-> out_psr[PSR_I]);

  a_r5_fiq_mask: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ret && (out_slot == SLOT_FIQ || out_slot == SLOT_RST)) |-> out_psr[PSR_F]);

  a_r6_state_bit: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ret) |-> (out_psr[PSR_T] == VEC_T));

  a_r7_bank_write: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> (out_valid && !out_ret && out_slot != SLOT_RST && bank_mode == out_psr[4:0]));

  a_r10_user_return: assert property (@(posedge clk) disable iff (rst)
    (ret_cmd && cur_psr[4:0] == MODE_USR && !req_irq && !req_fiq && others_idle) |=> !out_valid);

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r12_entry_wins: assert property (@(posedge clk) disable iff (rst)
    (ret_cmd && req_und) |=> (out_valid && !out_ret));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .AW(AW), .PW(PW), .VEC_BASE(VEC_BASE), .VEC_T(VEC_T)
) u_chk (
  .clk(clk), .rst(rst), .req_rst(req_rst), .req_und(req_und), .req_svc(req_svc),
  .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
  .ret_cmd(ret_cmd), .cur_psr(cur_psr), .out_valid(out_valid), .out_ret(out_ret),
  .out_slot(out_slot), .out_pc(out_pc), .out_psr(out_psr), .bank_we(bank_we),
  .bank_mode(bank_mode)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req = '0;   // bit i = request for slot i
  logic        ret_cmd = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_psr = 32'h0000_0010;
  logic        out_valid, out_ret, bank_we;
  logic [2:0]  out_slot;
  logic [31:0] out_pc, out_psr, bank_psr, bank_lr;
  logic [4:0]  bank_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst(rst),
    .req_rst(req[0]), .req_und(req[1]), .req_svc(req[2]), .req_pabt(req[3]),
    .req_dabt(req[4]), .req_irq(req[6]), .req_fiq(req[7]),
    .ret_cmd(ret_cmd), .cur_pc(cur_pc), .cur_psr(cur_psr),
    .out_valid(out_valid), .out_ret(out_ret), .out_slot(out_slot),
    .out_pc(out_pc), .out_psr(out_psr), .bank_we(bank_we),
    .bank_mode(bank_mode), .bank_psr(bank_psr), .bank_lr(bank_lr)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [31:0] psr;
    logic        v;
    logic [2:0]  slot;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 32'hA000_0010, 1'b1, 3'd1},
    '{8'h04, 32'hA000_0010, 1'b1, 3'd2},
    '{8'h06, 32'hA000_0010, 1'b1, 3'd1},
    '{8'h0A, 32'hA000_0010, 1'b1, 3'd3},
    '{8'h18, 32'hA000_0010, 1'b1, 3'd4},
    '{8'h48, 32'hA000_0030, 1'b1, 3'd6},
    '{8'hC0, 32'hA000_0010, 1'b1, 3'd7},
    '{8'hC0, 32'hA000_0050, 1'b1, 3'd6},
    '{8'h40, 32'hA000_0090, 1'b0, 3'd0},
    '{8'hC4, 32'hA000_00D0, 1'b1, 3'd2},
    '{8'hDF, 32'hA000_0010, 1'b1, 3'd0},
    '{8'h90, 32'hA000_0010, 1'b1, 3'd4},
    '{8'h80, 32'hA000_0090, 1'b1, 3'd7}
  };

  function automatic logic [4:0] exp_mode(input logic [2:0] s);
    case (s)
      3'd1:       return 5'b11011;
      3'd3, 3'd4: return 5'b10111;
      3'd6:       return 5'b10010;
      3'd7:       return 5'b10001;
      default:    return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] exp_psr(input logic [2:0] s, input logic [31:0] p);
    logic [31:0] r;
    r = (s == 3'd0) ? 32'h0000_0040 : p;
    r[4:0] = exp_mode(s);
    r[5] = 1'b0;
    r[7] = 1'b1;
    if (s == 3'd7) r[6] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] r, input logic rc, input logic [31:0] pc,
                       input logic [31:0] psr);
    @(negedge clk);
    req = r; ret_cmd = rc; cur_pc = pc; cur_psr = psr;
    @(posedge clk);
    #1;
    @(negedge clk);
    req = '0; ret_cmd = 1'b0;
    #0.5;
  endtask

  task automatic check_entry(input string tag, input logic [2:0] s, input logic [31:0] pc,
                             input logic [31:0] psr);
    logic [31:0] e;
    e = exp_psr(s, psr);
    chk({tag, " R11 valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " R12 not ret"}, {31'd0, out_ret}, 32'd0);
    chk({tag, " R2 slot"}, {29'd0, out_slot}, {29'd0, s});
    chk({tag, " R1 pc"}, out_pc, {27'd0, s, 2'b00});
    chk({tag, " R4 mode"}, {27'd0, out_psr[4:0]}, {27'd0, e[4:0]});
    chk({tag, " R5 masks"}, {30'd0, out_psr[7:6]}, {30'd0, e[7:6]});
    chk({tag, " R6 R8 rest"}, {out_psr[31:8], 3'd0, out_psr[5], 4'd0},
        {e[31:8], 3'd0, e[5], 4'd0});
    chk({tag, " R7 R8 bank_we"}, {31'd0, bank_we}, {31'd0, s != 3'd0});
    if (s != 3'd0) begin
      chk({tag, " R7 bank_mode"}, {27'd0, bank_mode}, {27'd0, e[4:0]});
      chk({tag, " R7 bank_psr"}, bank_psr, psr);
      chk({tag, " R7 bank_lr"}, bank_lr, pc);
    end
  endtask

  // watchdog
  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] p_svc, p_fiq;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R11 reset bank_we", {31'd0, bank_we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc;
      pc = 32'h1000 + 32'(i * 16);
      @(negedge clk);
      req = VECS[i].rq; cur_pc = pc; cur_psr = VECS[i].psr;
      @(posedge clk);
      #1;
      if (VECS[i].v) check_entry($sformatf("vec%0d", i), VECS[i].slot, pc, VECS[i].psr);
      else chk($sformatf("vec%0d R3 masked", i), {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      req = '0;
      @(posedge clk);
      #1;
      chk($sformatf("vec%0d R11 pulse ends", i), {31'd0, out_valid}, 32'd0);
    end

    // nested entries then unwinding returns (R9)
    drive(8'h04, 1'b0, 32'h2000, 32'hA000_0010);
    p_svc = out_psr;
    check_entry("nest svc", 3'd2, 32'h2000, 32'hA000_0010);
    drive(8'h80, 1'b0, 32'h3000, p_svc);
    p_fiq = out_psr;
    check_entry("nest fiq", 3'd7, 32'h3000, p_svc);

    drive(8'h00, 1'b1, 32'h0, p_fiq);
    chk("R9 ret fiq valid", {31'd0, out_valid}, 32'd1);
    chk("R9 ret fiq flag", {31'd0, out_ret}, 32'd1);
    chk("R9 ret fiq pc", out_pc, 32'h3000);
    chk("R9 ret fiq psr", out_psr, p_svc);
    chk("R9 ret no bank_we", {31'd0, bank_we}, 32'd0);

    drive(8'h00, 1'b1, 32'h0, p_svc);
    chk("R9 ret svc valid", {31'd0, out_valid & out_ret}, 32'd1);
    chk("R9 ret svc pc", out_pc, 32'h2000);
    chk("R9 ret svc psr", out_psr, 32'hA000_0010);

    drive(8'h00, 1'b1, 32'h0, 32'hA000_0010);
    chk("R10 user return ignored", {31'd0, out_valid}, 32'd0);
    drive(8'h00, 1'b1, 32'h0, 32'hA000_001F);
    chk("R10 unbanked mode ignored", {31'd0, out_valid}, 32'd0);

    drive(8'h02, 1'b1, 32'h4000, p_svc);
    chk("R12 entry over return", {31'd0, out_valid}, 32'd1);
    chk("R12 ret flag low", {31'd0, out_ret}, 32'd0);
    chk("R12 slot", {29'd0, out_slot}, 32'd1);

    // synchronous reset with request pending (R11)
    @(negedge clk);
    rst = 1'b1; req = 8'h02;
    @(posedge clk);
    #1;
    chk("R11 rst overrides request", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0; req = '0;
    @(posedge clk);
    #1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule